// File: doc/BRIEF.md
# Sliding-Window Recursion Scheduler

This block sequences the work of a window-by-window soft-output decoder for convolutional codes. It does no arithmetic on metrics and holds no metric storage. On every clock it states which recursion the datapath is running, which bit index it is working on, and which sub-cycle of that index it is in. It also drives read and write strobes for the input and forward-metric memories, a strobe marking each finished extrinsic output, and selects that tell the datapath how to seed each recursion.

A frame of `blk_len` bits is cut into windows of 128 indices. The last window takes whatever remains. Each window is handled in three phases. The forward pass walks the window upward at 7 cycles per index. Next, unless this is the last window, a warm-up pass of 7 cycles per index walks downward over the first 24 indices of the following window, or over all of that window if it is shorter. The backward pass then walks the window downward at 24 cycles per index. Each backward index spends 7 cycles on state metrics, 4 on transition metrics and 13 on the output value. A full-size window therefore costs 4136 cycles. Windows are finished in natural order. Bit indices start at 0.

Top module: `swsc_sched`

## Requirements
- R1: After reset, `phase` is 0 (idle), `done` is 0 and every strobe and select is 0.
- R2: A `start` seen while idle with 1 <= `blk_len` <= MAX_LEN (6144) moves the block, on the next cycle, to phase 1 (forward) at index 0 and step 0. A `start` with `blk_len` = 0, or any `start` while busy, has no effect.
- R3: In phase 1, every index lasts 7 cycles (steps 0..6) and indices rise by one. `alpha_wr` is high at step 6 exactly once per index, so the k-th write of a frame carries index k.
- R4: After the forward pass of every window except the last, phase 2 (warm-up) runs 7 cycles per index. It covers min(24, length of the next window) indices, descending to the next window's first index. `warm_init` is high on its first cycle. The last window has no warm-up.
- R5: In phase 3 (backward), every index lasts 24 cycles and indices fall from the window's top to its first index. `alpha_rd` is high at step 0 and `ext_valid` at step 23, so the outputs of window w come out from min(128w+127, blk_len-1) down to 128w.
- R6: `bwd_part` is 0 for steps 0..6, 1 for steps 7..10 and 2 for steps 11..23 while in phase 3. It is 3 in every other phase.
- R7: `llr_rd` is high exactly at step 0 of every index in phases 1, 2 and 3.
- R8: Windows span 128 indices and the last holds the remainder. The busy time of a frame is the sum over windows of 7·L + 24·L, plus 7·min(24, next length) for each window that has a next window.
- R9: At step 0 of a window's first forward index, `alpha_init_fixed` is high for window 0 and `alpha_init_carry` for later windows. At step 0 of a window's first backward index, `beta_init_fixed` is high for the last window and `beta_init_warm` for the others.
- R10: `done` pulses for one cycle, in the first idle cycle after the last output of the frame. A valid `start` in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame |
| blk_len | input | 13 | Frame length in bits |
| phase | output | 2 | 0 idle, 1 forward, 2 warm-up, 3 backward |
| bit_idx | output | 13 | Current bit index |
| step | output | 5 | Sub-cycle within the current index |
| bwd_part | output | 2 | Backward sub-stage: 0 state, 1 transition, 2 output, 3 none |
| llr_rd | output | 1 | Read input LLRs for `bit_idx` |
| alpha_wr | output | 1 | Write forward metrics for `bit_idx` |
| alpha_rd | output | 1 | Read forward metrics for `bit_idx` |
| ext_valid | output | 1 | Extrinsic output for `bit_idx` complete |
| alpha_init_fixed | output | 1 | Seed forward pass with fixed start metrics |
| alpha_init_carry | output | 1 | Seed forward pass from previous window |
| beta_init_fixed | output | 1 | Seed backward pass with fixed end metrics |
| beta_init_warm | output | 1 | Seed backward pass from warm-up result |
| warm_init | output | 1 | Seed warm-up pass |
| done | output | 1 | Frame finished |

## Verification
The end-of-frame `done` pulse and the acceptance of a new frame can fall in the same cycle. The bench provokes this by raising `start` in the very cycle `done` is observed. It then judges that one cycle later the block is in the forward phase with `alpha_init_fixed` high, and that the second frame runs to its full cycle count. A second coincidence is the first backward cycle of the last window, where `llr_rd`, `alpha_rd` and `beta_init_fixed` must all be high together. A one-index frame exercises this, and the bench checks all three strobes against its own model of the schedule.

// File: rtl/swsc_pkg.sv
package swsc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_WARM = 2'd2,
        PH_BWD  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        BP_STATE = 2'd0,
        BP_TRANS = 2'd1,
        BP_OUT   = 2'd2,
        BP_NONE  = 2'd3
    } bpart_t;

    // cycles spent per bit index in a given phase
    function automatic int phase_cycles(phase_t p, int fwd_c, int warm_c, int bwd_c);
        case (p)
            PH_FWD:  return fwd_c;
            PH_WARM: return warm_c;
            PH_BWD:  return bwd_c;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/swsc_step_ctr.sv
module swsc_step_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] step,
    output logic         wrap
);
    assign wrap = run && (step == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run || wrap) step <= '0;
        else                     step <= step + 1'b1;
    end

    // R3/R5: the sub-cycle never reaches the per-index length of the phase
    a_r3_step_below_limit: assert property (@(posedge clk) disable iff (rst)
        run |-> step < limit);

endmodule

// File: rtl/swsc_win_geom.sv
module swsc_win_geom #(
    parameter int CW       = 14,
    parameter int WIN_LEN  = 128,
    parameter int WARM_LEN = 24
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] top,
    output logic [CW-1:0] nxt_base,
    output logic [CW-1:0] warm_top,
    output logic          last
);
    logic [CW-1:0] rem, rem_nxt;

    always_comb begin
        rem      = len - base;
        last     = rem <= CW'(WIN_LEN);
        top      = last ? len - 1'b1 : base + CW'(WIN_LEN - 1);
        nxt_base = base + CW'(WIN_LEN);
        rem_nxt  = len - nxt_base;
        warm_top = (rem_nxt <= CW'(WARM_LEN)) ? len - 1'b1
                                              : nxt_base + CW'(WARM_LEN - 1);
    end

endmodule

// File: rtl/swsc_sched.sv
module swsc_sched
    import swsc_pkg::*;
#(
    parameter int MAX_LEN  = 6144,
    parameter int WIN_LEN  = 128,
    parameter int WARM_LEN = 24,
    parameter int FWD_CYC  = 7,
    parameter int WARM_CYC = 7,
    parameter int SM_CYC   = 7,
    parameter int TM_CYC   = 4,
    parameter int OUT_CYC  = 13,
    localparam int IDX_W   = $clog2(MAX_LEN + 1),
    localparam int BWD_CYC = SM_CYC + TM_CYC + OUT_CYC,
    localparam int STEP_W  = $clog2(BWD_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  blk_len,
    output logic [1:0]        phase,
    output logic [IDX_W-1:0]  bit_idx,
    output logic [STEP_W-1:0] step,
    output logic [1:0]        bwd_part,
    output logic              llr_rd,
    output logic              alpha_wr,
    output logic              alpha_rd,
    output logic              ext_valid,
    output logic              alpha_init_fixed,
    output logic              alpha_init_carry,
    output logic              beta_init_fixed,
    output logic              beta_init_warm,
    output logic              warm_init,
    output logic              done
);
    localparam int CW = IDX_W + 1;

    phase_t            ph;
    logic [IDX_W-1:0]  idx, base, len_q;
    logic              done_q;
    logic [STEP_W-1:0] lim, stp;
    logic              wrap, run, len_ok;
    logic [CW-1:0]     g_top, g_nxt, g_warm, idx_x;
    logic              g_last;
    bpart_t            part;

    assign run    = (ph != PH_IDLE);
    assign lim    = STEP_W'(phase_cycles(ph, FWD_CYC, WARM_CYC, BWD_CYC));
    assign len_ok = (blk_len != '0) && (blk_len <= IDX_W'(MAX_LEN));
    assign idx_x  = {1'b0, idx};

    swsc_step_ctr #(.W(STEP_W)) u_step (
        .clk(clk), .rst(rst), .run(run), .limit(lim), .step(stp), .wrap(wrap)
    );

    swsc_win_geom #(.CW(CW), .WIN_LEN(WIN_LEN), .WARM_LEN(WARM_LEN)) u_geom (
        .base({1'b0, base}), .len({1'b0, len_q}),
        .top(g_top), .nxt_base(g_nxt), .warm_top(g_warm), .last(g_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            idx    <= '0;
            base   <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: if (start && len_ok) begin
                    ph    <= PH_FWD;
                    idx   <= '0;
                    base  <= '0;
                    len_q <= blk_len;
                end
                PH_FWD: if (wrap) begin
                    if (idx_x != g_top)  idx <= idx + 1'b1;
                    else if (g_last) begin
                        ph  <= PH_BWD;
                        idx <= g_top[IDX_W-1:0];
                    end else begin
                        ph  <= PH_WARM;
                        idx <= g_warm[IDX_W-1:0];
                    end
                end
                PH_WARM: if (wrap) begin
                    if (idx_x != g_nxt) idx <= idx - 1'b1;
                    else begin
                        ph  <= PH_BWD;
                        idx <= g_top[IDX_W-1:0];
                    end
                end
                default: if (wrap) begin
                    if (idx != base)  idx <= idx - 1'b1;
                    else if (g_last) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        ph   <= PH_FWD;
                        base <= g_nxt[IDX_W-1:0];
                        idx  <= g_nxt[IDX_W-1:0];
                    end
                end
            endcase
        end
    end

    always_comb begin
        if (ph != PH_BWD)                          part = BP_NONE;
        else if (stp < STEP_W'(SM_CYC))            part = BP_STATE;
        else if (stp < STEP_W'(SM_CYC + TM_CYC))   part = BP_TRANS;
        else                                       part = BP_OUT;
    end

    assign phase            = ph;
    assign bit_idx          = idx;
    assign step             = stp;
    assign bwd_part         = part;
    assign done             = done_q;
    assign llr_rd           = run && (stp == '0);
    assign alpha_wr         = (ph == PH_FWD) && wrap;
    assign alpha_rd         = (ph == PH_BWD) && (stp == '0);
    assign ext_valid        = (ph == PH_BWD) && wrap;
    assign alpha_init_fixed = (ph == PH_FWD) && (stp == '0) && (idx == base) && (base == '0);
    assign alpha_init_carry = (ph == PH_FWD) && (stp == '0) && (idx == base) && (base != '0);
    assign beta_init_fixed  = (ph == PH_BWD) && (stp == '0) && (idx_x == g_top) && g_last;
    assign beta_init_warm   = (ph == PH_BWD) && (stp == '0) && (idx_x == g_top) && !g_last;
    assign warm_init        = (ph == PH_WARM) && (stp == '0) && (idx_x == g_warm);

    // R2: an accepted start opens the forward pass at index 0
    a_r2_start_opens_fwd: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && start && len_ok) |=> (ph == PH_FWD && idx == '0 && stp == '0));

    // R3: consecutive forward indices rise by one
    a_r3_fwd_ascends: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FWD && stp == '0 && $past(ph) == PH_FWD) |-> idx == $past(idx) + 1'b1);

    // R4: warm-up indices fall by one
    a_r4_warm_descends: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WARM && stp == '0 && $past(ph) == PH_WARM) |-> idx == $past(idx) - 1'b1);

    // R5: backward indices fall by one
    a_r5_bwd_descends: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_BWD && stp == '0 && $past(ph) == PH_BWD) |-> idx == $past(idx) - 1'b1);

    // R5: an output closes its index
    a_r5_out_ends_index: assert property (@(posedge clk) disable iff (rst)
        ext_valid |=> stp == '0);

    // R10: done only follows the backward pass
    a_r10_done_after_bwd: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (ph == PH_IDLE || ph == PH_FWD) && $past(ph) == PH_BWD);

endmodule

// File: tb/test_swsc_sched.sv
module test_swsc_sched;
    localparam int IDX_W = 13;
    localparam int NV    = 6;
    localparam int V_LEN  [NV] = '{1, 128, 129, 152, 256, 300};
    localparam int V_CYC  [NV] = '{31, 3968, 4006, 4880, 8104, 9636};
    localparam int V_WARM [NV] = '{0, 0, 7, 168, 168, 336};

    logic clk = 0, rst = 1, start = 0;
    logic [IDX_W-1:0] blk_len = '0;
    logic [1:0] phase, bwd_part;
    logic [IDX_W-1:0] bit_idx;
    logic [4:0] step;
    logic llr_rd, alpha_wr, alpha_rd, ext_valid, alpha_init_fixed, alpha_init_carry;
    logic beta_init_fixed, beta_init_warm, warm_init, done;

    swsc_sched i_swsc_sched (
        .clk(clk), .rst(rst), .start(start), .blk_len(blk_len), .phase(phase),
        .bit_idx(bit_idx), .step(step), .bwd_part(bwd_part), .llr_rd(llr_rd),
        .alpha_wr(alpha_wr), .alpha_rd(alpha_rd), .ext_valid(ext_valid),
        .alpha_init_fixed(alpha_init_fixed), .alpha_init_carry(alpha_init_carry),
        .beta_init_fixed(beta_init_fixed), .beta_init_warm(beta_init_warm),
        .warm_init(warm_init), .done(done)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cur_len = 1;
    int c_busy, c_fwd, c_warm, c_bwd, c_out, c_wr, c_rd;
    int c_aif, c_aic, c_bif, c_biw, c_wi, c_done;
    bit mon_on = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int out_idx(input int k, input int len);
        int w, top;
        w = k / 128;
        top = (w * 128 + 127 < len - 1) ? w * 128 + 127 : len - 1;
        return top - (k % 128);
    endfunction

    task automatic clear_counts();
        c_busy = 0; c_fwd = 0; c_warm = 0; c_bwd = 0; c_out = 0; c_wr = 0; c_rd = 0;
        c_aif = 0; c_aic = 0; c_bif = 0; c_biw = 0; c_wi = 0; c_done = 0;
    endtask

    always @(negedge clk) if (mon_on) begin
        if (phase != 0) c_busy++;
        if (phase == 1) c_fwd++;
        if (phase == 2) c_warm++;
        if (phase == 3) c_bwd++;
        // R7 read strobe at step 0 of every index
        chk(llr_rd == (phase != 0 && step == 0), "R7 llr_rd", llr_rd, (phase != 0 && step == 0));
        // R6 backward sub-stage
        if (phase == 3)
            chk(bwd_part == ((step < 7) ? 0 : (step < 11) ? 1 : 2), "R6 bwd_part", bwd_part,
                (step < 7) ? 0 : (step < 11) ? 1 : 2);
        else
            chk(bwd_part == 3, "R6 bwd_part idle", bwd_part, 3);
        if (alpha_wr) begin
            chk(bit_idx == c_wr && step == 6, "R3 alpha_wr index", bit_idx, c_wr);
            c_wr++;
        end
        if (alpha_rd) begin
            chk(bit_idx == out_idx(c_rd, cur_len), "R5 alpha_rd index", bit_idx, out_idx(c_rd, cur_len));
            c_rd++;
        end
        if (ext_valid) begin
            chk(bit_idx == out_idx(c_out, cur_len) && step == 23, "R5 output index",
                bit_idx, out_idx(c_out, cur_len));
            c_out++;
        end
        if (alpha_init_fixed) c_aif++;
        if (alpha_init_carry) c_aic++;
        if (beta_init_fixed) begin
            c_bif++;
            chk(alpha_rd && llr_rd, "R9 beta_init_fixed with reads", alpha_rd, 1);
        end
        if (beta_init_warm) c_biw++;
        if (warm_init) c_wi++;
        if (done) c_done++;
    end

    task automatic wait_done();
        do @(negedge clk); while (!done);
        #1;
    endtask

    task automatic judge(input int len, input int cyc, input int warm);
        int nw;
        nw = (len + 127) / 128;
        chk(c_busy == cyc, "R8 busy cycles", c_busy, cyc);
        chk(c_fwd == 7 * len, "R3 forward cycles", c_fwd, 7 * len);
        chk(c_bwd == 24 * len, "R5 backward cycles", c_bwd, 24 * len);
        chk(c_warm == warm, "R4 warm-up cycles", c_warm, warm);
        chk(c_wr == len, "R3 alpha writes", c_wr, len);
        chk(c_out == len && c_rd == len, "R5 outputs", c_out, len);
        chk(c_aif == 1 && c_aic == nw - 1, "R9 forward seeds", c_aic, nw - 1);
        chk(c_bif == 1 && c_biw == nw - 1, "R9 backward seeds", c_biw, nw - 1);
        chk(c_wi == nw - 1, "R4 warm_init count", c_wi, nw - 1);
        chk(c_done == 1 && phase == 0, "R10 done pulse", c_done, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(phase == 0 && !done && !llr_rd && !alpha_wr && !alpha_rd && !ext_valid &&
            !alpha_init_fixed && !alpha_init_carry && !beta_init_fixed && !beta_init_warm &&
            !warm_init && bwd_part == 3, "R1 reset state", phase, 0);
        rst = 0;
        @(negedge clk);

        // R2 zero length start is ignored
        start = 1; blk_len = '0;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk(phase == 0, "R2 zero-length start ignored", phase, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            clear_counts();
            cur_len = V_LEN[v];
            mon_on = 1;
            start = 1; blk_len = IDX_W'(V_LEN[v]);
            @(negedge clk);
            start = 0;
            chk(phase == 1 && bit_idx == 0 && step == 0, "R2 start opens forward", phase, 1);
            wait_done();
            judge(V_LEN[v], V_CYC[v], V_WARM[v]);
        end

        // R2 start while busy has no effect
        clear_counts();
        cur_len = 1;
        start = 1; blk_len = 1;
        @(negedge clk);
        start = 0;
        repeat (10) @(negedge clk);
        start = 1; blk_len = 128;
        @(negedge clk);
        start = 0;
        wait_done();
        judge(1, 31, 0);

        // R10 new start in the done cycle is accepted
        clear_counts();
        start = 1; blk_len = 1;
        @(negedge clk);
        start = 0;
        do @(negedge clk); while (!done);
        start = 1; blk_len = 1;
        @(negedge clk);
        start = 0;
        chk(phase == 1 && alpha_init_fixed, "R10 start in done cycle", phase, 1);
        #1;
        clear_counts();
        c_busy = 1; c_fwd = 1; c_aif = 1;
        wait_done();
        judge(1, 31, 0);

        mon_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule